// File: doc/BRIEF.md
# Chained-NAND Board Connectivity Test Logic

This block lets automatic test equipment check the solder joints of a chip's digital pins without any software. The pins under test feed a chain of two-input NAND stages. The chain's result leaves on a pin that normally serves as an address input. A second shared pin acts as the test request. While the chip has not yet seen a write to its configuration register, the block samples that pin on every clock. If it is high, the block enters test mode. From then on the shared output pin drives the chain result. Otherwise the pin passes its value to the core as an address bit.

The first configuration write sets a lockout flag. Only a power-on reset clears that flag. While the flag is set, test mode cannot be entered again, whatever the request pin does. If test mode is active when the write arrives, the write ends it. The tester drives every chained pin high, which makes the output high. It then pulls the pins low one at a time, in chain order starting at index 0. Each step toggles the output. A pin with a bad joint shows up as a missing toggle.

Top module: `nand_tree_test`

## Requirements
- R1: After reset, `tree_oe_o` is 0, `tree_o` is 0 and the lockout flag is clear, so a later request can still enter test mode.
- R2: With the lockout clear and no write in the same cycle, `test_en_i` high at a rising clock edge sets `tree_oe_o` to 1 from that edge on.
- R3: After any `cfg_wr_i` pulse, `test_en_i` has no effect: `tree_oe_o` stays 0 until the next reset.
- R4: A `cfg_wr_i` pulse while in test mode makes `tree_oe_o` 0 from that edge on.
- R5: When `cfg_wr_i` and `test_en_i` are both high at the same edge, the write wins: test mode is not entered.
- R6: In test mode, with every bit of `tree_pins_i` high, `tree_o` is 1.
- R7: In test mode, starting from all pins high and pulling bit 0, then bit 1, and so on up to the top bit low (earlier bits stay low), each step toggles `tree_o`.
- R8: In test mode, `tree_o` is combinational in `tree_pins_i`. If j is the highest index with a low bit, `tree_o` equals bit 0 of j (1 when j is odd). If no bit is low, `tree_o` is 1.
- R9: Outside test mode, `tree_o` is 0 and `tree_oe_o` is 0, for any `tree_pins_i`.
- R10: Outside test mode, `addr0_core_o` follows `pad_addr0_i`. In test mode it is 0.
- R11: Once entered, test mode stays active when `test_en_i` falls. A reset clears both the mode and the lockout, so entry works again after a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cfg_wr_i | input | 1 | One-cycle strobe for a configuration-register write |
| test_en_i | input | 1 | Test request from the shared pin |
| tree_pins_i | input | N_PINS | Chained pin inputs, index 0 first in the toggle order |
| pad_addr0_i | input | 1 | Value on the shared address/test-output pin |
| tree_o | output | 1 | Chain result for the shared pin |
| tree_oe_o | output | 1 | Output enable for the shared pin (test mode) |
| addr0_core_o | output | 1 | Address bit passed to the core |

## Verification
The two functions that can land in the same cycle are test-mode entry and the lockout set by the first write. The bench raises `test_en_i` and `cfg_wr_i` together, right after reset. It then expects `tree_oe_o` to stay 0 at that edge and at every later edge with the request held high. It also pulses the write while test mode is active and judges the exit in the very next sample. The chain itself is checked against a highest-low-index parity rule that the bench computes on its own. Checks use a directed walk and random vectors.

// File: rtl/nt_pkg.sv
package nt_pkg;
  // Output-side correction so the chain reads 1 with every input high.
  function automatic logic nt_end_fix(input int unsigned n);
    return logic'(n % 2);
  endfunction
endpackage

// File: rtl/nt_lockout.sv
module nt_lockout (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr_i,
  input  logic test_en_i,
  output logic mode_o
);
  logic lock_q, mode_q;
  logic entry_ev, exit_ev;

  assign entry_ev = !lock_q && test_en_i && !cfg_wr_i;
  assign exit_ev  = cfg_wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (exit_ev) begin
        lock_q <= 1'b1;
        mode_q <= 1'b0;
      end else if (entry_ev) begin
        mode_q <= 1'b1;
      end
    end
  end

  assign mode_o = mode_q;

  a_r2_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && test_en_i && !cfg_wr_i) |=> mode_o);
  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  a_r4_write_exits: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_i |=> !mode_o);
  a_r11_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o && !cfg_wr_i) |=> mode_o);
endmodule

// File: rtl/nt_chain.sv
module nt_chain #(
  parameter int unsigned N_PINS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pins_i,
  output logic              chain_o
);
  import nt_pkg::*;
  localparam logic END_FIX = nt_end_fix(N_PINS);

  logic [N_PINS-1:0] stage;

  assign stage[0] = ~pins_i[0];
  for (genvar k = 1; k < N_PINS; k++) begin : g_stage
    assign stage[k] = ~(pins_i[k] & stage[k-1]);
  end

  assign chain_o = stage[N_PINS-1] ^ END_FIX;

  a_r6_all_high: assert property (@(posedge clk) disable iff (!rst_n)
    (&pins_i) |-> chain_o);
  a_r8_top_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!pins_i[N_PINS-1]) |-> (chain_o == logic'((N_PINS-1) % 2)));
endmodule

// File: rtl/nt_pin_mux.sv
module nt_pin_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic chain_i,
  input  logic pad_addr0_i,
  output logic tree_o,
  output logic tree_oe_o,
  output logic addr0_core_o
);
  assign tree_oe_o    = mode_i;
  assign tree_o       = mode_i & chain_i;
  assign addr0_core_o = ~mode_i & pad_addr0_i;

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tree_oe_o |-> !tree_o);
  a_r10_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !tree_oe_o |-> (addr0_core_o == pad_addr0_i));
  a_r10_addr_blk: assert property (@(posedge clk) disable iff (!rst_n)
    tree_oe_o |-> !addr0_core_o);
endmodule

// File: rtl/nand_tree_test.sv
module nand_tree_test #(
  parameter int unsigned N_PINS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_i,
  input  logic              test_en_i,
  input  logic [N_PINS-1:0] tree_pins_i,
  input  logic              pad_addr0_i,
  output logic              tree_o,
  output logic              tree_oe_o,
  output logic              addr0_core_o
);
  logic mode_w, chain_w;

  nt_lockout u_lock (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr_i),
    .test_en_i(test_en_i), .mode_o(mode_w)
  );

  nt_chain #(.N_PINS(N_PINS)) u_chain (
    .clk(clk), .rst_n(rst_n), .pins_i(tree_pins_i), .chain_o(chain_w)
  );

  nt_pin_mux u_mux (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_w), .chain_i(chain_w),
    .pad_addr0_i(pad_addr0_i), .tree_o(tree_o), .tree_oe_o(tree_oe_o),
    .addr0_core_o(addr0_core_o)
  );

  a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i && test_en_i) |=> !tree_oe_o);
endmodule

// File: tb/nand_tree_test_tb_top.sv
module nand_tree_test_tb_top;
  localparam int N = 12;
  logic clk = 0, rst_n = 0, cfg_wr = 0, ten = 0, pad = 0;
  logic [N-1:0] pins = '1;
  logic tree, oe, acore;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  nand_tree_test #(.N_PINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .test_en_i(ten),
    .tree_pins_i(pins), .pad_addr0_i(pad), .tree_o(tree),
    .tree_oe_o(oe), .addr0_core_o(acore)
  );

  function automatic logic exp_tree(input logic [N-1:0] v);
    for (int j = N-1; j >= 0; j--)
      if (!v[j]) return logic'(j & 1);
    return 1'b1;
  endfunction

  task automatic chk(input string rq, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", rq, act, expv);
    end
  endtask

  task automatic step(); @(negedge clk); #1; endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; cfg_wr = 0; ten = 0;
    @(negedge clk); @(negedge clk); rst_n = 1; #1;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic prev;
    void'($urandom(32'h5A17));
    do_reset();
    // R1 reset state, R9/R10 normal mode
    chk("R1 oe", oe, 1'b0); chk("R1 tree", tree, 1'b0);
    pad = 1; pins = 12'h0F0; #1;
    chk("R9 tree quiet", tree, 1'b0); chk("R10 addr pass", acore, 1'b1);
    pad = 0; #1; chk("R10 addr pass 0", acore, 1'b0);
    step(); step();
    // R2 entry
    ten = 1; step();
    chk("R2 entry", oe, 1'b1);
    ten = 0; step(); step();
    chk("R11 hold after fall", oe, 1'b1);
    pad = 1; #1; chk("R10 addr blocked", acore, 1'b0);
    // R6 all high, R7 walk
    pins = '1; #1; chk("R6 all high", tree, 1'b1);
    prev = tree;
    for (int i = 0; i < N; i++) begin
      pins[i] = 1'b0; #1;
      chk("R7 toggle", tree, ~prev);
      chk("R8 walk", tree, exp_tree(pins));
      prev = tree;
    end
    // R8 random vectors
    for (int r = 0; r < 60; r++) begin
      step();
      pins = N'($urandom);
      if (r % 7 == 0) pins = '1;
      #1; chk("R8 random", tree, exp_tree(pins));
    end
    // R4 exit by write
    @(negedge clk); cfg_wr = 1; step(); cfg_wr = 0;
    chk("R4 exit", oe, 1'b0);
    pins = 12'h000; #1; chk("R9 tree quiet after exit", tree, 1'b0);
    chk("R10 addr after exit", acore, pad);
    // R3 lockout
    ten = 1;
    for (int c = 0; c < 5; c++) begin step(); chk("R3 locked", oe, 1'b0); end
    ten = 0;
    // R5 same-cycle collision
    do_reset();
    @(negedge clk); cfg_wr = 1; ten = 1; step(); cfg_wr = 0;
    chk("R5 write wins", oe, 1'b0);
    for (int c = 0; c < 4; c++) begin step(); chk("R5 stays locked", oe, 1'b0); end
    ten = 0;
    // R11 reset clears lockout
    do_reset();
    chk("R1 oe after reset", oe, 1'b0);
    ten = 1; step(); ten = 0;
    chk("R11 re-entry after reset", oe, 1'b1);
    pins = '1; #1; chk("R6 all high again", tree, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule